// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write-Once Action Field

This block is a watchdog timer for a processor subsystem. A free-running counter advances either on every core clock or once per rising edge of an external tick input. The edge is synchronised and detected inside the block. A software-chosen counter bit sets the period. A timeout occurs when that bit changes from 0 to 1.

The first timeout sets a status bit and raises an interrupt. If software services the watchdog, the first stage is armed again. If a second timeout arrives while the status bit is still set, the block copies the two-bit action code into a captured-code field. It then acts on that code. Code 01 drives a sticky checkstop output. Code 10 drives a sticky reset-request output. Codes 00 and 11 cause no action. Once software writes a non-zero action code, the code can no longer be changed; only a hardware reset clears it.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational from the read address.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, every register reads 0, the counter reads 0, and `wd_irq`, `checkstop` and `reset_req` are low.
- R2: The control register is at address 0. Bits [1:0] hold the action code, bit 2 is the count enable, bit 3 is the tick select, and bits [7:4] hold the tap index. The action code takes the written value only while it holds 00. Once it is non-zero, every write to it, including 11, leaves it unchanged. The other control bits accept every write.
- R3: The counter reads back at address 2. With the enable at 0 the counter holds. With the enable at 1 and tick select at 0, it advances by one on every clock. With tick select at 1, it advances by exactly one per rising edge of `tick_in`, and the core clock alone does not advance it.
- R4: A timeout is a counter increment that takes counter bit [tap] from 0 to 1. A timeout while status bit 0 is clear sets status bit 0 (address 1), and `wd_irq` follows that bit.
- R5: Writing address 1 with data bit 0 set, or pulsing `svc_clr`, clears status bit 0. Writing address 1 with data bit 0 clear leaves it unchanged.
- R6: A timeout while status bit 0 is set is a second timeout. It copies the action code into status bits [2:1] and sets status bit 3.
- R7: On a second timeout, code 01 raises `checkstop` and code 10 raises `reset_req`. Codes 00 and 11 raise neither. Both outputs stay high until reset, and they are never high together.
- R8: When a timeout and a clear fall in the same cycle, the timeout is judged on the status bit before the clear. If the bit was clear, it ends up set. If it was set, the second-timeout action is taken and the bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Asynchronous external time-base tick |
| svc_clr | input | 1 | Service pulse, clears first-stage status |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data |
| wd_irq | output | 1 | First-stage interrupt request |
| checkstop | output | 1 | Sticky checkstop request |
| reset_req | output | 1 | Sticky reset request |

## Verification
A timeout and a service clear can land on the same clock edge. The outcome then depends on whether the first stage was already armed. The bench provokes this directly: it reads the counter until it sits one step before the tap bit rises, then pulses `svc_clr` for that cycle. It does this once with the status bit clear and once with it set, and compares the status and reset-request outputs one cycle later. Random service pulses and clear writes against a short period hit the same collision many more times. Those results are judged against a cycle-by-cycle model kept in the bench.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          svc_clr,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wd_irq,
  output logic          checkstop,
  output logic          reset_req
);
  localparam int TAP_W = $clog2(CNT_W);

  logic [1:0]       act_code;
  logic             tb_en;
  logic             tick_sel;
  logic [TAP_W-1:0] tap;
  logic [CNT_W-1:0] cnt;
  logic             wis;
  logic             fired;
  logic [1:0]       cap_code;
  logic [1:0]       tsync;
  logic             tick_d;

  wire              tick_rise = tsync[1] & ~tick_d;
  wire              step      = tb_en & (tick_sel ? tick_rise : 1'b1);
  wire  [CNT_W-1:0] cnt_inc   = cnt + 1'b1;
  wire              tmo       = step & ~cnt[tap] & cnt_inc[tap];
  wire              ctl_wr    = wr_en && (wr_addr == 2'd0);
  wire              clr       = svc_clr | (wr_en && (wr_addr == 2'd1) && wr_data[0]);

  assign wd_irq = wis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_code  <= '0;
      tb_en     <= 1'b0;
      tick_sel  <= 1'b0;
      tap       <= '0;
      cnt       <= '0;
      wis       <= 1'b0;
      fired     <= 1'b0;
      cap_code  <= '0;
      tsync     <= '0;
      tick_d    <= 1'b0;
      checkstop <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      tsync  <= {tsync[0], tick_in};
      tick_d <= tsync[1];
      if (step) cnt <= cnt_inc;
      if (ctl_wr) begin
        tb_en    <= wr_data[2];
        tick_sel <= wr_data[3];
        tap      <= wr_data[4 +: TAP_W];
        if (act_code == 2'b00) act_code <= wr_data[1:0];
      end
      if (tmo && !wis) wis <= 1'b1;
      else if (clr)    wis <= 1'b0;
      if (tmo && wis) begin
        fired    <= 1'b1;
        cap_code <= act_code;
        if (act_code == 2'b01) checkstop <= 1'b1;
        if (act_code == 2'b10) reset_req <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0: begin
        rd_data[1:0]       = act_code;
        rd_data[2]         = tb_en;
        rd_data[3]         = tick_sel;
        rd_data[4 +: TAP_W] = tap;
      end
      2'd1: begin
        rd_data[0]   = wis;
        rd_data[2:1] = cap_code;
        rd_data[3]   = fired;
      end
      2'd2: rd_data[CNT_W-1:0] = cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tb_en,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       act_code,
  input logic             wis,
  input logic             fired,
  input logic [1:0]       cap_code,
  input logic             checkstop,
  input logic             reset_req
);
  assert_code_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code != 2'b00) |=> $stable(act_code));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> $stable(cnt));

  assert_second_needs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> $past(wis));

  assert_capture_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> (cap_code == $past(act_code)));

  assert_checkstop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(checkstop) |-> ($past(wis) && $past(act_code) == 2'b01));

  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(wis) && $past(act_code) == 2'b10));

  assert_checkstop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop);

  assert_reset_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(checkstop && reset_req));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_en     (tb_en),
  .cnt       (cnt),
  .act_code  (act_code),
  .wis       (wis),
  .fired     (fired),
  .cap_code  (cap_code),
  .checkstop (checkstop),
  .reset_req (reset_req)
);

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        svc_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wd_irq, checkstop, reset_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  wdog_twostage uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .svc_clr(svc_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wd_irq(wd_irq), .checkstop(checkstop), .reset_req(reset_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit f_tmo(input logic [15:0] c, input int t);
    logic [15:0] n;
    n = c + 16'd1;
    return !c[t] && n[t];
  endfunction

  function automatic logic [15:0] f_ctl(input logic [1:0] code, input bit en, input bit sel, input int t);
    return 16'((t << 4) | (sel << 3) | (en << 2) | code);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; svc_clr = 1'b0; wr_en = 1'b0; tick_in = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_cnt_low3(input logic [2:0] v);
    logic [15:0] d;
    for (int i = 0; i < 100; i++) begin
      rd(2'd2, d);
      if (d[2:0] == v) break;
      @(negedge clk);
    end
  endtask

  logic [15:0] d;
  logic [15:0] m_cnt;
  bit m_wis, m_fired, m_chk, m_rr, m_tmo, m_clr, s_svc, s_w1c;
  logic [1:0] m_cap;

  initial begin
    void'($urandom(32'd4021));
    do_reset();

    // R1 reset state
    rd(2'd0, d); check("R1 ctl", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 count", d, 0);
    check("R1 outputs", {wd_irq, checkstop, reset_req}, 0);

    // R2 write-once action code
    wr(2'd0, f_ctl(2'b10, 0, 0, 5));
    rd(2'd0, d); check("R2 first write", d, f_ctl(2'b10, 0, 0, 5));
    wr(2'd0, f_ctl(2'b01, 0, 1, 7));
    rd(2'd0, d); check("R2 locked code other bits free", d, f_ctl(2'b10, 0, 1, 7));
    wr(2'd0, f_ctl(2'b00, 0, 0, 7));
    rd(2'd0, d); check("R2 no clear", d[1:0], 2'b10);
    do_reset();
    wr(2'd0, f_ctl(2'b11, 0, 0, 0));
    wr(2'd0, f_ctl(2'b01, 0, 0, 0));
    rd(2'd0, d); check("R2 reserved locks", d[1:0], 2'b11);

    // R3 enable off holds
    idle(10);
    rd(2'd2, d); check("R3 disabled hold", d, 0);

    // R3 tick mode
    do_reset();
    wr(2'd0, f_ctl(2'b00, 1, 1, 15));
    idle(20);
    rd(2'd2, d); check("R3 tick mode no clock count", d, 0);
    for (int i = 0; i < 5; i++) begin
      tick_in = 1'b1; idle(3); tick_in = 1'b0; idle(3);
    end
    idle(4);
    rd(2'd2, d); check("R3 five tick edges", d, 5);

    // R4/R5/R6/R7 with code 01, tap 3 (first timeout at 8th increment)
    do_reset();
    wr(2'd0, f_ctl(2'b01, 1, 0, 3));
    idle(7);
    check("R4 no early timeout", wd_irq, 0);
    idle(3);
    rd(2'd1, d); check("R4 first timeout status", d, 1);
    check("R4 irq and no action", {wd_irq, checkstop, reset_req}, 3'b100);
    wr(2'd1, 16'h0000);
    check("R5 write 0 no effect", wd_irq, 1);
    wr(2'd1, 16'h0001);
    check("R5 W1C clears", wd_irq, 0);
    idle(16);
    check("R4 rearmed timeout", wd_irq, 1);
    svc_clr = 1'b1; idle(1); svc_clr = 1'b0;
    check("R5 service clears", wd_irq, 0);
    idle(16);
    check("R4 status again", wd_irq, 1);
    idle(16);
    rd(2'd1, d); check("R6 capture code 01", d, 16'h000B);
    check("R7 checkstop", {checkstop, reset_req}, 2'b10);
    wr(2'd1, 16'h0001); idle(40);
    check("R7 checkstop sticky", {checkstop, reset_req}, 2'b10);

    // R7 codes 10, 11, 00
    for (int c = 0; c < 3; c++) begin
      logic [1:0] code;
      code = (c == 0) ? 2'b10 : (c == 1) ? 2'b11 : 2'b00;
      do_reset();
      wr(2'd0, f_ctl(code, 1, 0, 3));
      idle(30);
      rd(2'd1, d);
      check("R6 captured code", d[3:1], {1'b1, code});
      check("R7 action outputs", {checkstop, reset_req}, {1'b0, code == 2'b10});
    end

    // R8 directed collision, tap 2 (timeout on count ...3 -> ...4)
    do_reset();
    wr(2'd0, f_ctl(2'b10, 1, 0, 2));
    wait_cnt_low3(3'd3);
    svc_clr = 1'b1; @(negedge clk); svc_clr = 1'b0;
    rd(2'd1, d);
    check("R8 first timeout beats clear", {d[0], reset_req}, 2'b10);
    wait_cnt_low3(3'd3);
    svc_clr = 1'b1; @(negedge clk); svc_clr = 1'b0;
    rd(2'd1, d);
    check("R8 second timeout with clear", {d[0], d[3], reset_req}, 3'b011);

    // Random rounds against bench model (R4 R5 R6 R7 R8)
    for (int r = 0; r < 4; r++) begin
      int t;
      logic [1:0] code;
      code = 2'(r);
      t = 1 + int'($urandom_range(1, 0));
      do_reset();
      wr(2'd0, f_ctl(code, 1, 0, t));
      m_cnt = 0; m_wis = 0; m_fired = 0; m_chk = 0; m_rr = 0; m_cap = 0;
      for (int k = 0; k < 300; k++) begin
        rd(2'd1, d);
        check("R8 random model status/outputs",
              {checkstop, reset_req, wd_irq, d[3:0]},
              {m_chk, m_rr, m_wis, m_fired, m_cap, m_wis});
        s_svc = ($urandom_range(5, 0) == 0);
        s_w1c = ($urandom_range(7, 0) == 0);
        svc_clr = s_svc;
        wr_en = s_w1c; wr_addr = 2'd1; wr_data = 16'($urandom_range(3, 0));
        m_tmo = f_tmo(m_cnt, t);
        m_clr = s_svc || (s_w1c && wr_data[0]);
        if (m_tmo && m_wis) begin
          m_fired = 1; m_cap = code;
          if (code == 2'b01) m_chk = 1;
          if (code == 2'b10) m_rr = 1;
        end
        if (m_tmo && !m_wis) m_wis = 1;
        else if (m_clr) m_wis = 0;
        m_cnt = m_cnt + 16'd1;
        @(negedge clk);
      end
      svc_clr = 1'b0; wr_en = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule